// File: doc/BRIEF.md
# I2C master byte engine

This block is a register-driven I2C bus master that moves one byte per software handshake. Software loads the data register, writes a mode and a start request into the status register, and the engine generates a START condition and shifts the byte out on the open-drain SCL and SDA lines. After the acknowledge clock it raises a pending flag and holds SCL low. While the flag is set, software reads the acknowledge result or the received byte, loads the next byte or queues a repeated START or a STOP, and then clears the flag to let the bus move again.

The SCL rate comes from a prescaler of 16 or 256 followed by a 4-bit divider. Each bit time is cut into four equal quarters. The ACK bit that the master drives in receive mode follows a control bit, so software can answer the last byte of a read with NACK. An interrupt output reports the pending flag when interrupts are enabled.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset every register reads zero, both line drivers are released (`scl_oe` and `sda_oe` low) and `irq` is low.
- R2: Register word offsets are 0 control, 1 status, 2 own address and 3 data. Control holds the divider in bits [3:0], pending in bit 4, interrupt enable in bit 5, prescaler select in bit 6 and ACK generate in bit 7. Bit 8 always reads 0. Own address and data read back what was written. Status reads mode in [7:6], busy in 5, enable in 4, arbitration in 3 and NACK in 0.
- R3: Within a byte the SCL period is (divider+1)×16 input clocks when prescaler select is 0, and (divider+1)×256 clocks when it is 1.
- R4: A status write with bit 5 and bit 4 set while the bus is idle makes SDA fall while SCL is high and sets busy. It then transmits the data register MSB first, and data bits change only while SCL is low.
- R5: At the end of each acknowledge clock the pending bit sets and SCL stays low until a control write has bit 4 = 0 or bit 8 = 1. Writing bit 4 = 1 never sets pending.
- R6: Status bit 0 holds the level sampled on SDA during the acknowledge clock: 1 means NACK.
- R7: In receive mode (status [7:6] = 2'b10), a byte after the address is shifted in MSB first and can be read from the data register. The master drives ACK low when control bit 7 is 1 and leaves SDA released (NACK) when it is 0.
- R8: A status write with bit 5 = 1 and bit 4 = 1 while pending is set gives, once pending is cleared, a repeated START with no STOP before it. The data register is then sent as an address byte.
- R9: A status write with bit 5 = 0 and bit 4 = 1 while pending is set gives, once pending is cleared, a STOP condition (SDA rising while SCL is high). Busy then clears and both lines are released.
- R10: `irq` equals pending AND interrupt enable.
- R11: Status bit 3 sets when SDA reads low while the master sends a 1 bit, and clears at the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register word offset |
| reg_wdata | input | DIV_W+5 (9) | Register write data |
| reg_rdata | output | DIV_W+5 (9) | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level, asynchronous |

## Verification
The bench builds the block with its default parameters: prescalers of 16 and 256, a 4-bit divider, 8-bit bytes and a two-stage input synchroniser. With the divider at 0 and the small prescaler, a quarter bit is four clocks, so each byte takes about 150 clocks. This lets one run cover many complete write, read, repeated-START and STOP sequences against a bus slave model. The same defaults keep the large prescaler and non-zero divider settings cheap enough to measure the SCL period directly.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_HOLD,
        ST_STOP
    } eng_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_START,
        CMD_STOP
    } cmd_e;

    localparam int OFS_CTRL = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_OWN  = 2;
    localparam int OFS_DATA = 3;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/i2cm_tick_gen.sv
module i2cm_tick_gen #(
    parameter int PRESC_LO = 16,
    parameter int PRESC_HI = 256,
    parameter int DIV_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             presc_sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int Q_LO  = PRESC_LO / 4;
    localparam int Q_HI  = PRESC_HI / 4;
    localparam int MAXQ  = Q_HI * (2 ** DIV_W);
    localparam int CNT_W = $clog2(MAXQ);
    localparam int LW    = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [LW-1:0]    lim;

    always_comb begin
        lim   = LW'(presc_sel ? Q_HI : Q_LO) * (LW'(div) + LW'(1)) - LW'(1);
        tick  = run && (cnt_q == lim[CNT_W-1:0]);
        cnt_d = cnt_q + CNT_W'(1);
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // quarter counter never runs past its limit
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ({1'b0, cnt_q} <= lim));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go_start,
    input  logic              go_stop,
    input  logic              go_next,
    input  logic              mode_tx,
    input  logic              ack_gen,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] data_wdata,
    input  logic              sda_s,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              nack,
    output logic              arb,
    output logic              byte_done,
    output logic [BYTE_W-1:0] data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    typedef struct packed {
        eng_state_e        st;
        logic [1:0]        ph;
        logic [CNT_W-1:0]  bitn;
        logic [BYTE_W-1:0] data;
        logic              first;
        logic              busy;
        logic              nack;
        logic              arb;
        logic              done;
    } eng_t;

    eng_t d, q;
    logic rx_byte;

    always_comb begin
        rx_byte = !q.first && !mode_tx;
        d       = q;
        d.done  = 1'b0;
        if (data_we) d.data = data_wdata;
        unique case (q.st)
            ST_IDLE: if (go_start) begin
                d.st = ST_START; d.ph = '0; d.busy = 1'b1;
                d.arb = 1'b0; d.first = 1'b1;
            end
            ST_START: if (tick) begin
                if (q.ph == 2'd3) begin
                    d.st = ST_BIT; d.ph = '0; d.bitn = '0;
                end else d.ph = q.ph + 2'd1;
            end
            ST_BIT: if (tick) begin
                if (q.ph == 2'd2) begin
                    if (q.bitn == LAST)  d.nack = sda_s;
                    else if (rx_byte)    d.data = {q.data[BYTE_W-2:0], sda_s};
                    else if (q.data[BYTE_W-1] && !sda_s) d.arb = 1'b1;
                end
                if (q.ph == 2'd3) begin
                    d.ph = '0;
                    if (q.bitn == LAST) begin
                        d.st = ST_HOLD; d.done = 1'b1; d.first = 1'b0;
                    end else begin
                        d.bitn = q.bitn + CNT_W'(1);
                        if (!rx_byte) d.data = {q.data[BYTE_W-2:0], q.data[BYTE_W-1]};
                    end
                end else d.ph = q.ph + 2'd1;
            end
            ST_HOLD: begin
                if (go_start) begin
                    d.st = ST_START; d.ph = '0; d.arb = 1'b0; d.first = 1'b1;
                end else if (go_stop) begin
                    d.st = ST_STOP; d.ph = '0;
                end else if (go_next) begin
                    d.st = ST_BIT; d.ph = '0; d.bitn = '0;
                end
            end
            ST_STOP: if (tick) begin
                if (q.ph == 2'd3) begin
                    d.st = ST_IDLE; d.ph = '0; d.busy = 1'b0;
                end else d.ph = q.ph + 2'd1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (q.st)
            ST_START: begin
                scl_oe = (q.ph == 2'd0) || (q.ph == 2'd3);
                sda_oe = q.ph[1];
            end
            ST_BIT: begin
                scl_oe = (q.ph == 2'd0) || (q.ph == 2'd3);
                if (q.bitn == LAST) sda_oe = rx_byte && ack_gen;
                else                sda_oe = !rx_byte && !q.data[BYTE_W-1];
            end
            ST_HOLD: scl_oe = 1'b1;
            ST_STOP: begin
                scl_oe = (q.ph == 2'd0);
                sda_oe = !q.ph[1];
            end
            default: ;
        endcase
    end

    assign busy      = q.busy;
    assign nack      = q.nack;
    assign arb       = q.arb;
    assign byte_done = q.done;
    assign data      = q.data;

    // SDA keeps its level across the SCL-high part of a bit
    p_sda_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BIT && q.ph == 2'd2 && $past(q.st) == ST_BIT) |-> $stable(sda_oe));
    // engine never leaves idle without a start request
    p_idle_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_IDLE && q.st != ST_IDLE) |-> $past(go_start));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int PRESC_LO    = 16,
    parameter int PRESC_HI    = 256,
    parameter int DIV_W       = 4,
    parameter int BYTE_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    localparam int REG_W      = DIV_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    localparam int PEND_B = DIV_W;
    localparam int IEN_B  = DIV_W + 1;
    localparam int PRE_B  = DIV_W + 2;
    localparam int ACK_B  = DIV_W + 3;
    localparam int CLR_B  = DIV_W + 4;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              pend;
        logic              ien;
        logic              presc;
        logic              ackgen;
        logic [1:0]        mode;
        logic              en;
        logic [BYTE_W-1:0] own;
        cmd_e              cmd;
    } regs_t;

    regs_t d, q;
    logic ctrl_wr, stat_wr, clear, go_start, go_stop, go_next;
    logic tick, sda_s;
    logic eng_busy, eng_nack, eng_arb, eng_done;
    logic [BYTE_W-1:0] eng_data;

    i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_s)
    );

    i2cm_tick_gen #(.PRESC_LO(PRESC_LO), .PRESC_HI(PRESC_HI), .DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .presc_sel(q.presc),
        .div(q.div), .tick(tick)
    );

    i2cm_engine #(.BYTE_W(BYTE_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .go_start(go_start), .go_stop(go_stop), .go_next(go_next),
        .mode_tx(q.mode == 2'b11), .ack_gen(q.ackgen),
        .data_we(reg_wr && reg_addr == A_DATA), .data_wdata(reg_wdata[BYTE_W-1:0]),
        .sda_s(sda_s), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(eng_busy),
        .nack(eng_nack), .arb(eng_arb), .byte_done(eng_done), .data(eng_data)
    );

    always_comb begin
        d        = q;
        go_start = 1'b0;
        go_stop  = 1'b0;
        go_next  = 1'b0;
        ctrl_wr  = reg_wr && reg_addr == A_CTRL;
        stat_wr  = reg_wr && reg_addr == A_STAT;
        clear    = ctrl_wr && (reg_wdata[CLR_B] || !reg_wdata[PEND_B]);
        if (ctrl_wr) begin
            d.div    = reg_wdata[DIV_W-1:0];
            d.ien    = reg_wdata[IEN_B];
            d.presc  = reg_wdata[PRE_B];
            d.ackgen = reg_wdata[ACK_B];
        end
        if (reg_wr && reg_addr == A_OWN) d.own = reg_wdata[BYTE_W-1:0];
        if (stat_wr) begin
            d.mode = reg_wdata[7:6];
            d.en   = reg_wdata[4];
            if (eng_busy && q.pend) begin
                if (reg_wdata[4]) d.cmd = reg_wdata[5] ? CMD_START : CMD_STOP;
            end else if (!eng_busy && reg_wdata[5] && reg_wdata[4]) begin
                go_start = 1'b1;
            end
        end
        if (q.pend && clear) begin
            unique case (q.cmd)
                CMD_START: go_start = 1'b1;
                CMD_STOP:  go_stop  = 1'b1;
                default:   go_next  = 1'b1;
            endcase
            d.cmd = CMD_NONE;
        end
        if (eng_done)   d.pend = 1'b1;
        else if (clear) d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cmd: CMD_NONE, default: '0};
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {1'b0, q.ackgen, q.presc, q.ien, q.pend, q.div};
            A_STAT:  reg_rdata = REG_W'({q.mode, eng_busy, q.en, eng_arb, 2'b00, eng_nack});
            A_OWN:   reg_rdata = REG_W'(q.own);
            A_DATA:  reg_rdata = REG_W'(eng_data);
            default: reg_rdata = '0;
        endcase
    end

    assign irq = q.pend && q.ien;

    // clock line stays low for as long as software has not released the byte
    p_hold_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend |-> scl_oe);
    // a start request makes the bus busy on the next cycle
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        go_start |=> eng_busy);
    // leaving busy happens with both lines released
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_busy) |-> (!scl_oe && !sda_oe));
    // an interrupt only appears during an active transfer
    p_irq_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> eng_busy);
endmodule

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [8:0] reg_wdata = '0;
    logic [8:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       slv_low = 1'b0, force_low = 1'b0;
    wire        scl = ~scl_oe;
    wire        sda = ~(sda_oe | slv_low | force_low);

    i2c_byte_master u_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda)
    );

    int checks = 0, fails = 0;
    logic [6:0] slv_addr = 7'h52;
    logic [7:0] txb = 8'hC3;

    // bus slave model
    logic scl_p = 1'b1, sda_p = 1'b1, first = 1'b0, rdm = 1'b0, matched = 1'b0, mack = 1'b1;
    int   pos = -1, starts = 0, stops = 0, rx_cnt = 0;
    logic [7:0] sh = '0, last_rx = '0;
    always @(negedge clk) begin
        if (scl && scl_p && sda_p && !sda) begin
            starts++; pos = -1; first = 1'b1; slv_low = 1'b0;
        end else if (scl && scl_p && !sda_p && sda) begin
            stops++; pos = -1; matched = 1'b0; slv_low = 1'b0;
        end else if (scl && !scl_p) begin
            if (pos >= 0 && pos < 8) sh = {sh[6:0], sda};
            else if (pos == 8) mack = sda;
        end else if (!scl && scl_p) begin
            if (pos == -1) begin
                pos = 0; slv_low = 1'b0;
            end else if (pos < 7) begin
                pos++;
                slv_low = (!first && rdm && matched) ? !txb[7-pos] : 1'b0;
            end else if (pos == 7) begin
                pos = 8;
                if (first) begin
                    matched = (sh[7:1] == slv_addr); rdm = sh[0]; slv_low = matched;
                end else if (!rdm && matched) begin
                    slv_low = 1'b1; last_rx = sh; rx_cnt++;
                end else slv_low = 1'b0;
            end else begin
                pos = 0;
                if (first) begin
                    first = 1'b0; slv_low = (matched && rdm) ? !txb[7] : 1'b0;
                end else if (rdm && matched && !mack) slv_low = !txb[7];
                else begin
                    slv_low = 1'b0; if (rdm) matched = 1'b0;
                end
            end
        end
        scl_p = scl; sda_p = sda;
    end

    // SCL period monitor
    int cyc = 0, last_rise = 0, per = 0;
    logic scl_m = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (scl && !scl_m) begin per = cyc - last_rise; last_rise = cyc; end
        scl_m = scl;
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [8:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [8:0] v);
        @(negedge clk); reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic wait_pend(input string req);
        logic [8:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd0, v);
            if (v[4]) return;
        end
        chk(req, 0, 1);
    endtask

    task automatic wait_idle(input string req);
        logic [8:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd1, v);
            if (!v[5]) return;
        end
        chk(req, 0, 1);
    endtask

    task automatic stop_bus(input logic [8:0] stat, input logic [8:0] ctrl);
        wr(3'd1, stat);
        wr(3'd0, ctrl & 9'h0EF);
        wait_idle("R9 idle");
    endtask

    task automatic t_reset();
        logic [8:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v); chk("R1 reg zero", v, 0);
        end
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_regs();
        logic [8:0] v;
        wr(3'd0, 9'h0EB); rd(3'd0, v); chk("R2 ctrl readback", v, 9'h0EB);
        wr(3'd0, 9'h1FB); rd(3'd0, v); chk("R5 pend not set by write", v, 9'h0EB);
        chk("R10 irq idle", irq, 0);
        wr(3'd2, 9'h0A7); rd(3'd2, v); chk("R2 own addr", v, 9'h0A7);
        wr(3'd3, 9'h03C); rd(3'd3, v); chk("R2 data", v, 9'h03C);
        wr(3'd1, 9'h0C0); rd(3'd1, v); chk("R2 status no enable", v, 9'h0C0);
        repeat (40) @(negedge clk);
        chk("R4 no start without enable", scl_oe, 0);
        wr(3'd0, 9'h000);
    endtask

    task automatic t_write();
        logic [8:0] v;
        int s0, p0, r0;
        wr(3'd0, 9'h0A0);
        wr(3'd3, {1'b0, slv_addr, 1'b0});
        s0 = starts; r0 = rx_cnt;
        wr(3'd1, 9'h0F0);
        wait_pend("R5 pend after address");
        chk("R4 start seen", 32'(starts), 32'(s0 + 1));
        rd(3'd1, v); chk("R6 status ack busy", v, 9'h0F0);
        chk("R10 irq with enable", irq, 1);
        chk("R3 period div0 p16", 32'(per), 16);
        repeat (100) @(negedge clk);
        chk("R5 scl held", scl_oe, 1);
        rd(3'd0, v); chk("R5 pend stays", v[4], 1);
        wr(3'd3, 9'h05A);
        wr(3'd0, 9'h0A0);
        wait_pend("R5 pend after data");
        chk("R4 data byte", last_rx, 8'h5A);
        chk("R4 one data byte", 32'(rx_cnt), 32'(r0 + 1));
        p0 = stops;
        wr(3'd1, 9'h0D0);
        wr(3'd0, 9'h1B0);
        wait_idle("R9 idle");
        chk("R9 stop seen", 32'(stops), 32'(p0 + 1));
        chk("R9 scl released", scl_oe, 0);
        chk("R9 sda released", sda_oe, 0);
        chk("R10 irq cleared", irq, 0);
    endtask

    task automatic t_nack();
        logic [8:0] v;
        wr(3'd0, 9'h080);
        wr(3'd3, 9'h022);
        wr(3'd1, 9'h0F0);
        wait_pend("R5 pend nack");
        rd(3'd1, v); chk("R6 nack flag", v[0], 1);
        chk("R10 irq masked", irq, 0);
        stop_bus(9'h0D0, 9'h080);
    endtask

    task automatic t_read();
        logic [8:0] v;
        int s0, p0;
        wr(3'd0, 9'h0A0);
        wr(3'd3, {1'b0, slv_addr, 1'b0});
        wr(3'd1, 9'h0F0);
        wait_pend("R5 pend rd addr");
        wr(3'd3, 9'h010);
        wr(3'd0, 9'h0A0);
        wait_pend("R5 pend rd reg");
        chk("R4 register byte", last_rx, 8'h10);
        wr(3'd3, {1'b0, slv_addr, 1'b1});
        s0 = starts; p0 = stops;
        wr(3'd1, 9'h0B0);
        wr(3'd0, 9'h0A0);
        wait_pend("R5 pend rep start");
        chk("R8 repeated start", 32'(starts), 32'(s0 + 1));
        chk("R8 no stop", 32'(stops), 32'(p0));
        rd(3'd1, v); chk("R8 read addr acked", v[0], 0);
        wr(3'd0, 9'h0A0);
        wait_pend("R5 pend rx1");
        rd(3'd3, v); chk("R7 first rx byte", v, 9'h0C3);
        chk("R7 master ack", mack, 0);
        wr(3'd0, 9'h020);
        wait_pend("R5 pend rx2");
        rd(3'd3, v); chk("R7 last rx byte", v, 9'h0C3);
        chk("R7 master nack", mack, 1);
        stop_bus(9'h090, 9'h020);
        chk("R9 stop after read", 32'(stops), 32'(p0 + 1));
    endtask

    task automatic t_clock(input logic [8:0] ctrl, input int exp);
        wr(3'd0, ctrl);
        wr(3'd3, 9'h022);
        wr(3'd1, 9'h0F0);
        wait_pend("R5 pend clock");
        chk("R3 scl period", 32'(per), 32'(exp));
        stop_bus(9'h0D0, ctrl);
    endtask

    task automatic t_arb();
        logic [8:0] v;
        wr(3'd0, 9'h080);
        wr(3'd3, 9'h022);
        wr(3'd1, 9'h0F0);
        wait_pend("R5 pend arb");
        rd(3'd1, v); chk("R11 arb clear", v[3], 0);
        force_low = 1'b1;
        wr(3'd3, 9'h0FF);
        wr(3'd0, 9'h080);
        wait_pend("R5 pend arb byte");
        rd(3'd1, v); chk("R11 arb set", v[3], 1);
        force_low = 1'b0;
        stop_bus(9'h0D0, 9'h080);
        wr(3'd3, 9'h022);
        wr(3'd1, 9'h0F0);
        wait_pend("R5 pend arb restart");
        rd(3'd1, v); chk("R11 arb cleared by start", v[3], 0);
        stop_bus(9'h0D0, 9'h080);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regs();
        t_write();
        t_nack();
        t_read();
        t_clock(9'h040, 256);
        t_clock(9'h003, 64);
        t_arb();
        finish_run();
    end
endmodule